// File: doc/BRIEF.md
# Event Derandomizer Write Manager

This block sits in a detector front end and runs at the bunch-crossing rate. Each cycle it may receive one event: a 12-bit crossing identifier, a per-channel hit mask and the raw value of every channel, together with the decoded fast-control commands for that crossing. From these it builds a 24-bit event header and decides what gets stored in a derandomizing FIFO. The FIFO's depth is set at compile time, and a link packer downstream drains it through a show-ahead read port.

An event is stored as a header only when it carries no payload, when it is vetoed, or when header-only readout was requested. In that case the size field is zero, so the receiving side knows no data follows. When the FIFO is close to full, the block keeps the header, drops the payload and marks the header as truncated. It never stalls. A front-end reset or a synchronisation command empties the FIFO. In non-zero-suppressed mode every channel is packed, whatever its hit state.

Top module: `derand_wr_mgr`

## Requirements
- R1: Each FIFO entry is {header, data}, with the 24-bit header in the top bits. The header holds the crossing id in bits [23:12], the status in bits [11:8] and the data size in bits [7:0]. The status bits are: bit 8 truncated, bit 9 NZS mode, bit 10 veto command, bit 11 header-only command. `hdrOut` shows the header of the last written entry.
- R2: An event is still written as one entry when it has no hit channel (zero-suppressed), when `cmdBxVeto` is set, or when `cmdHeaderOnly` is set. Its size field is 0 and its data field is all zeros.
- R3: In zero-suppressed mode, data bits [NUM_CH-1:0] carry the hit pattern. From bit NUM_CH upward, the values of the hit channels are packed with no gaps, in ascending channel order. Unused bits are zero. The size is hits*CH_W + NUM_CH, saturating at 255.
- R4: When `cmdNzs` is set, every channel is treated as hit. The pattern is all ones, all channel values are packed, and the size is NUM_CH*(CH_W+1), saturating at 255.
- R5: An event that would carry data but arrives while the FIFO level is at least DEPTH-MARGIN is written with size 0, zero data and status bit 8 set. `truncFlag` pulses for it, and `truncCount` counts each truncated event that is written.
- R6: When `cmdFeReset` or `cmdSynch` is high on a clock edge, the FIFO is empty after that edge. An event and a read presented at the same edge are discarded.
- R7: Entries are read in the order they were written. `rdValid` is high while the FIFO holds entries, and `rdWord` shows the oldest entry. A read on an empty FIFO is ignored, and a read together with a write leaves the level unchanged.
- R8: An event arriving when the FIFO holds DEPTH entries is discarded, even if a read happens at the same edge. It sets `overflow`, which stays set until `rstN` is asserted low.
- R9: While and just after `rstN` is low, the FIFO is empty, `wrStrobe`, `truncFlag` and `overflow` are 0, and `truncCount` is 0.
- R10: `wrStrobe`, `wrWord`, `hdrOut` and `truncFlag` describe the event accepted at a clock edge, from that edge until the next one. An event that is not accepted leaves `wrStrobe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evValid | input | 1 | An event is presented this cycle |
| bxId | input | 12 | Crossing identifier of the event |
| hitMask | input | NUM_CH | Per-channel hit flags |
| chData | input | NUM_CH*CH_W | Channel values, channel i at bits [i*CH_W +: CH_W] |
| cmdBxVeto | input | 1 | Veto command for this crossing |
| cmdHeaderOnly | input | 1 | Header-only command for this crossing |
| cmdNzs | input | 1 | Non-zero-suppressed readout for this crossing |
| cmdFeReset | input | 1 | Front-end reset: flush FIFO |
| cmdSynch | input | 1 | Synchronisation command: flush FIFO |
| rdEn | input | 1 | Pop the oldest entry |
| rdValid | output | 1 | FIFO not empty |
| rdWord | output | ENTRY_W | Oldest entry (show-ahead) |
| wrStrobe | output | 1 | An entry was written at the last edge |
| wrWord | output | ENTRY_W | Entry written at the last edge |
| hdrOut | output | 24 | Header of that entry |
| truncFlag | output | 1 | That entry was truncated |
| truncCount | output | CNT_W | Number of truncated entries written |
| overflow | output | 1 | Sticky: an event was lost to a full FIFO |

## Verification
Assertions check a set of invariants on every cycle. A flush always leaves the FIFO empty, and the level never goes above the depth. Every entry with a zero size carries a zero data field. A truncated entry always has size zero. The overflow flag never falls and the truncation count never decreases while out of reset. The exact bit placement of packed channels, the choice between a data entry, a header-only entry and a truncated entry, and the read order across flushes and near-full stretches are only shown by the bench. It compares every written entry and every FIFO head against its own reference queue, under random and directed traffic.

// File: rtl/derand_pkg.sv
package derand_pkg;
  localparam int HDR_W  = 24;
  localparam int BX_W   = 12;
  localparam int STAT_W = 4;
  localparam int SIZE_W = 8;

  typedef struct packed {
    logic [BX_W-1:0]   bxId;
    logic [STAT_W-1:0] status;  // {headerOnly, veto, nzs, truncated}
    logic [SIZE_W-1:0] size;
  } evHeader_t;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic wrEn;
    logic keepData;
    logic trunc;
  } ctrlStrb_t;
endpackage

// File: rtl/derand_ctrl.sv
module derand_ctrl
  import derand_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int MARGIN = 4,
  parameter int CNT_W  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  input  logic             cmdFeReset,
  input  logic             cmdSynch,
  input  logic             cmdBxVeto,
  input  logic             cmdHeaderOnly,
  input  logic             anyPayload,
  input  logic [LVL_W-1:0] level,
  input  logic             full,
  output ctrlStrb_t        strb,
  output logic [CNT_W-1:0] truncCount,
  output logic             overflow
);
  localparam int AF_LEVEL = DEPTH - MARGIN;

  logic take, suppress, almostFull;

  always_comb begin
    take       = evValid & ~(cmdFeReset | cmdSynch);
    suppress   = cmdBxVeto | cmdHeaderOnly | ~anyPayload;
    almostFull = level >= LVL_W'(AF_LEVEL);
    strb.flush    = cmdFeReset | cmdSynch;
    strb.wrEn     = take & ~full;
    strb.trunc    = take & ~suppress & almostFull;
    strb.keepData = take & ~suppress & ~almostFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow   <= 1'b0;
      truncCount <= '0;
    end else begin
      if (take && full) overflow <= 1'b1;
      if (strb.trunc && strb.wrEn && truncCount != '1)
        truncCount <= truncCount + CNT_W'(1);
    end
  end

  // R8: overflow is sticky
  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  // R5: truncation count never decreases
  assert_trunc_count_monotonic_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> truncCount >= $past(truncCount));
endmodule

// File: rtl/derand_datapath.sv
module derand_datapath
  import derand_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int CH_W    = 4,
  parameter int DEPTH   = 16,
  parameter bit HIT_PAT = 1'b1,
  localparam int PAT_W   = HIT_PAT ? NUM_CH : 0,
  localparam int DATA_W  = NUM_CH * CH_W + PAT_W,
  localparam int ENTRY_W = HDR_W + DATA_W,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [BX_W-1:0]        bxId,
  input  logic [NUM_CH-1:0]      hitMask,
  input  logic [NUM_CH*CH_W-1:0] chData,
  input  logic                   cmdNzs,
  input  logic                   cmdBxVeto,
  input  logic                   cmdHeaderOnly,
  input  ctrlStrb_t              strb,
  input  logic                   rdEn,
  output logic                   anyPayload,
  output logic [LVL_W-1:0]       level,
  output logic                   full,
  output logic                   rdValid,
  output logic [ENTRY_W-1:0]     rdWord,
  output logic                   wrStrobe,
  output logic [ENTRY_W-1:0]     wrWord,
  output logic                   truncFlag
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int HCNT_W = $clog2(NUM_CH + 1);

  logic [NUM_CH-1:0]  sel;
  logic [HCNT_W-1:0]  hits;
  logic [DATA_W-1:0]  chanPacked, dataWord;
  logic [15:0]        rawSize;
  logic [SIZE_W-1:0]  sizeSat;
  evHeader_t          hdr;
  logic [ENTRY_W-1:0] entry;

  // dense packing of selected channels above the hit pattern
  always_comb begin
    sel        = cmdNzs ? '1 : hitMask;
    hits       = '0;
    chanPacked = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel[i]) begin
        chanPacked = chanPacked |
          (DATA_W'(chData[i*CH_W +: CH_W]) << (PAT_W + int'(hits) * CH_W));
        hits = hits + HCNT_W'(1);
      end
    end
  end

  generate
    if (PAT_W > 0) begin : g_pattern
      assign dataWord = chanPacked | DATA_W'(sel);
    end else begin : g_no_pattern
      assign dataWord = chanPacked;
    end
  endgenerate

  always_comb begin
    anyPayload = (hits != '0);
    rawSize    = 16'(hits) * 16'(CH_W) + ((PAT_W > 0 && anyPayload) ? 16'(PAT_W) : 16'd0);
    sizeSat    = (rawSize > 16'd255) ? 8'hFF : rawSize[SIZE_W-1:0];
    hdr.bxId   = bxId;
    hdr.status = {cmdHeaderOnly, cmdBxVeto, cmdNzs, strb.trunc};
    hdr.size   = strb.keepData ? sizeSat : '0;
    entry      = {hdr, (strb.keepData ? dataWord : {DATA_W{1'b0}})};
  end

  // derandomizing storage
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [LVL_W-1:0]   count;
  logic               rdEff;

  assign full    = (count == LVL_W'(DEPTH));
  assign level   = count;
  assign rdValid = (count != '0);
  assign rdWord  = mem[rdPtr];
  assign rdEff   = rdEn & rdValid;

  always_ff @(posedge clk) begin
    if (strb.wrEn && !strb.flush) mem[wrPtr] <= entry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      wrStrobe  <= 1'b0;
      truncFlag <= 1'b0;
      wrWord    <= '0;
    end else begin
      wrStrobe  <= strb.wrEn;
      truncFlag <= strb.wrEn & strb.trunc;
      if (strb.wrEn) wrWord <= entry;
      if (strb.flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (strb.wrEn) wrPtr <= wrPtr + PTR_W'(1);
        if (rdEff)     rdPtr <= rdPtr + PTR_W'(1);
        count <= count + LVL_W'(strb.wrEn) - LVL_W'(rdEff);
      end
    end
  end

  // R6: a flush leaves the FIFO empty
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (count == '0));
  // R8: the level never exceeds the depth
  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    count <= LVL_W'(DEPTH));
  // R2: zero size means zero data
  assert_hdr_only_no_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrWord[DATA_W +: SIZE_W] == '0) |-> (wrWord[DATA_W-1:0] == '0));
  // R5: truncated entries carry the status bit and no size
  assert_trunc_header_R5: assert property (@(posedge clk) disable iff (!rstN)
    truncFlag |-> (wrWord[DATA_W + SIZE_W] && wrWord[DATA_W +: SIZE_W] == '0));
endmodule

// File: rtl/derand_wr_mgr.sv
module derand_wr_mgr
  import derand_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int CH_W    = 4,
  parameter int DEPTH   = 16,
  parameter int MARGIN  = 4,
  parameter bit HIT_PAT = 1'b1,
  parameter int CNT_W   = 16,
  localparam int ENTRY_W = HDR_W + NUM_CH * CH_W + (HIT_PAT ? NUM_CH : 0)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   evValid,
  input  logic [BX_W-1:0]        bxId,
  input  logic [NUM_CH-1:0]      hitMask,
  input  logic [NUM_CH*CH_W-1:0] chData,
  input  logic                   cmdBxVeto,
  input  logic                   cmdHeaderOnly,
  input  logic                   cmdNzs,
  input  logic                   cmdFeReset,
  input  logic                   cmdSynch,
  input  logic                   rdEn,
  output logic                   rdValid,
  output logic [ENTRY_W-1:0]     rdWord,
  output logic                   wrStrobe,
  output logic [ENTRY_W-1:0]     wrWord,
  output logic [HDR_W-1:0]       hdrOut,
  output logic                   truncFlag,
  output logic [CNT_W-1:0]       truncCount,
  output logic                   overflow
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  ctrlStrb_t        strb;
  logic             anyPayload, full;
  logic [LVL_W-1:0] level;

  derand_ctrl #(.DEPTH(DEPTH), .MARGIN(MARGIN), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rstN, .evValid, .cmdFeReset, .cmdSynch, .cmdBxVeto, .cmdHeaderOnly,
    .anyPayload, .level, .full, .strb, .truncCount, .overflow
  );

  derand_datapath #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DEPTH(DEPTH), .HIT_PAT(HIT_PAT)) u_dp (
    .clk, .rstN, .bxId, .hitMask, .chData, .cmdNzs, .cmdBxVeto, .cmdHeaderOnly,
    .strb, .rdEn, .anyPayload, .level, .full, .rdValid, .rdWord,
    .wrStrobe, .wrWord, .truncFlag
  );

  assign hdrOut = wrWord[ENTRY_W-1 -: HDR_W];
endmodule

// File: tb/tb_derand_wr_mgr.sv
module tb_derand_wr_mgr;
  localparam int NUM_CH  = 8;
  localparam int CH_W    = 4;
  localparam int DEPTH   = 16;
  localparam int MARGIN  = 4;
  localparam int DATA_W  = NUM_CH * CH_W + NUM_CH;
  localparam int ENTRY_W = 24 + DATA_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evValid = 0, cmdBxVeto = 0, cmdHeaderOnly = 0, cmdNzs = 0;
  logic cmdFeReset = 0, cmdSynch = 0, rdEn = 0;
  logic [11:0] bxId = '0;
  logic [NUM_CH-1:0] hitMask = '0;
  logic [NUM_CH*CH_W-1:0] chData = '0;
  logic rdValid, wrStrobe, truncFlag, overflow;
  logic [ENTRY_W-1:0] rdWord, wrWord;
  logic [23:0] hdrOut;
  logic [15:0] truncCount;

  always #2 clk = ~clk;

  derand_wr_mgr #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DEPTH(DEPTH), .MARGIN(MARGIN),
                  .HIT_PAT(1'b1), .CNT_W(16)) dut (
    .clk, .rstN, .evValid, .bxId, .hitMask, .chData, .cmdBxVeto, .cmdHeaderOnly,
    .cmdNzs, .cmdFeReset, .cmdSynch, .rdEn, .rdValid, .rdWord, .wrStrobe, .wrWord,
    .hdrOut, .truncFlag, .truncCount, .overflow
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [ENTRY_W-1:0] q[$];
  int expTc = 0;
  logic expOvf = 0;

  task automatic chk(input string tag, input logic [ENTRY_W-1:0] act, input logic [ENTRY_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [ENTRY_W-1:0] refEntry(
    input logic [11:0] bx, input logic [NUM_CH-1:0] mask, input logic [NUM_CH*CH_W-1:0] d,
    input logic veto, input logic ho, input logic nzs, input int lvl,
    output logic tr, output string tag);
    logic [NUM_CH-1:0] sel;
    logic [DATA_W-1:0] dw;
    int hits, pos, sz;
    logic sup, keep;
    sel = nzs ? '1 : mask;
    hits = $countones(sel);
    dw = '0;
    dw[NUM_CH-1:0] = sel;
    pos = NUM_CH;
    for (int i = 0; i < NUM_CH; i++)
      if (sel[i]) begin
        for (int b = 0; b < CH_W; b++) dw[pos + b] = d[i*CH_W + b];
        pos += CH_W;
      end
    sup  = veto | ho | (hits == 0);
    tr   = !sup && (lvl >= DEPTH - MARGIN);
    keep = !sup && !tr;
    sz   = keep ? hits * CH_W + NUM_CH : 0;
    if (sz > 255) sz = 255;
    tag = tr ? "R5" : sup ? "R2" : nzs ? "R4" : "R3";
    return {bx, ho, veto, nzs, tr, 8'(sz), (keep ? dw : {DATA_W{1'b0}})};
  endfunction

  task automatic checkState(input string qtag);
    chk("R8", ENTRY_W'(overflow), ENTRY_W'(expOvf));
    chk("R5", ENTRY_W'(truncCount), ENTRY_W'(expTc));
    chk(qtag, ENTRY_W'(rdValid), ENTRY_W'(q.size() > 0));
    if (q.size() > 0) chk("R7", rdWord, q[0]);
  endtask

  task automatic step(input logic v, input logic [11:0] bx, input logic [NUM_CH-1:0] mask,
                      input logic [NUM_CH*CH_W-1:0] d, input logic veto, input logic ho,
                      input logic nzs, input logic fe, input logic syn, input logic rd);
    logic tr, flush, take, wr;
    logic [ENTRY_W-1:0] e;
    string tag;
    int pre;
    evValid = v; bxId = bx; hitMask = mask; chData = d; cmdBxVeto = veto;
    cmdHeaderOnly = ho; cmdNzs = nzs; cmdFeReset = fe; cmdSynch = syn; rdEn = rd;
    flush = fe | syn;
    take  = v && !flush;
    pre   = q.size();
    e     = refEntry(bx, mask, d, veto, ho, nzs, pre, tr, tag);
    wr    = take && (pre < DEPTH);
    @(posedge clk);
    if (flush) q.delete();
    else begin
      if (rd && q.size() > 0) void'(q.pop_front());
      if (wr) q.push_back(e);
    end
    if (take && pre == DEPTH) expOvf = 1;
    if (wr && tr) expTc++;
    @(negedge clk);
    chk("R10", ENTRY_W'(wrStrobe), ENTRY_W'(wr));
    if (wr) begin
      chk(tag, wrWord, e);
      chk("R1", ENTRY_W'(hdrOut), ENTRY_W'(e[ENTRY_W-1 -: 24]));
      chk("R5", ENTRY_W'(truncFlag), ENTRY_W'(tr));
    end
    checkState(flush ? "R6" : "R7");
  endtask

  task automatic doReset();
    rstN = 0;
    evValid = 0; rdEn = 0; cmdFeReset = 0; cmdSynch = 0;
    repeat (2) @(negedge clk);
    q.delete(); expTc = 0; expOvf = 0;
    chk("R9", ENTRY_W'({wrStrobe, truncFlag, overflow, rdValid}), '0);
    chk("R9", ENTRY_W'(truncCount), '0);
    rstN = 1;
    @(negedge clk);
    chk("R9", ENTRY_W'({wrStrobe, rdValid}), '0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240607);
    @(negedge clk);
    doReset();
    // R3 zero-suppressed packing
    step(1, 12'hABC, 8'b1010_0101, 32'h8765_4321, 0, 0, 0, 0, 0, 0);
    // R2 no hits, veto, header-only
    step(1, 12'h001, 8'h00, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    step(1, 12'h002, 8'hFF, 32'h1234_5678, 1, 0, 0, 0, 0, 0);
    step(1, 12'h003, 8'h0F, 32'h1234_5678, 0, 1, 0, 0, 0, 0);
    // R4 non-zero-suppressed, mask ignored
    step(1, 12'h004, 8'h00, 32'hCAFE_F00D, 0, 0, 1, 0, 0, 0);
    // R7 simultaneous read and write, then drain and read on empty
    step(1, 12'h005, 8'h80, 32'hA000_0000, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R5 fill to the truncation threshold, then R8 overflow
    for (int i = 0; i < DEPTH + 3; i++)
      step(1, 12'(16 + i), 8'h03, 32'(i * 7), 0, 0, 0, 0, 0, 0);
    // R6 synch flush discards its event, then FE reset flush
    step(1, 12'h0EE, 8'hFF, 32'h1, 0, 0, 0, 0, 1, 1);
    step(1, 12'h0EF, 8'hFF, 32'h2, 0, 0, 0, 0, 0, 0);
    step(1, 12'h0F0, 8'hFF, 32'h3, 0, 0, 0, 1, 0, 0);
    // R8 overflow stays until reset; R9
    doReset();
    for (int c = 0; c < 4000; c++) begin
      logic rd;
      int rdPct;
      rdPct = ((c / 500) % 2 == 0) ? 90 : 30;
      rd = ($urandom % 100) < rdPct;
      step(($urandom % 10) != 0, 12'($urandom), NUM_CH'($urandom), 32'($urandom),
           ($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 8) == 0,
           ($urandom % 128) == 0, ($urandom % 128) == 0, rd);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule